// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block creates the row-scan timing for a dot-matrix LCD driver from a free-running oscillator clock. It divides the oscillator down to a line clock. The divide ratio depends on the selected duty. It counts the scanned lines of each frame and adds a programmable first-row offset to form the display-RAM row address. It flips an AC polarity signal once per frame and gives a one-cycle strobe when a new frame begins.

For each segment, the block takes the RAM bit of the addressed row and applies the blanking, all-lit and inverted-image controls to it. The result is registered as the segment lit pattern.

Two copies can share a panel. The copy configured as the timing source drives its line clock, frame polarity and blanking state on three outputs. The copy configured as the follower takes those three signals as inputs and scans one oscillator cycle behind the source.

Top module: `lcd_scan_timing`

## Requirements
- R1: A synchronous reset (`rst` high) clears the divider, the line counter, the first-row offset and the frame polarity. It also clears the blank/all-lit/invert flags, which leaves the display blanked. After reset `ram_row_addr` is 0, `seg_out` is all zeros, `frame_pol_out` is 0 and, in source mode, `disp_off_out` is 1.
- R2: In source mode, `line_clk_out` has a period of 8 oscillator cycles for duty codes 0, 1 and 2. For duty code 3 the period is 4 cycles. It rises on the same edge as the line counter advances and stays high for half the period.
- R3: `duty_sel` selects the lines per frame: code 0 gives 9, code 1 gives 17, code 2 gives 33 and code 3 gives 65. The line counter runs from 0 to that count minus 1 and then returns to 0, so each frame holds exactly that many line-clock rises.
- R4: When the line counter wraps to 0, the frame polarity flips and `frame_start` is high for exactly that one cycle. At no other time does the polarity change or the strobe fire.
- R5: `ram_row_addr` equals (first-row offset + line count) modulo 65. The offset is loaded from `start_val` when `start_we` is high. A write with a value above 64 is ignored and the previous offset is kept.
- R6: One cycle after an oscillator edge, `seg_out` shows `ram_row_data` sampled at that edge while the display is lit. The pattern is taken as is in normal mode and inverted bit by bit when the invert flag is set. The flags are loaded from `cfg_disp_on`, `cfg_reverse` and `cfg_all_on` when `cfg_we` is high.
- R7: Blanking has priority over all-lit, and all-lit has priority over invert. While blanked, every bit of `seg_out` is 0. While all-lit and not blanked, every bit is 1, whatever the RAM data.
- R8: In source mode (`is_master` = 1), `disp_off_out` is 1 exactly when the stored display-on flag is 0. `frame_pol_out` carries the frame polarity.
- R9: In follower mode (`is_master` = 0), a rising edge on `line_clk_in` advances the line counter. A change on `frame_pol_in` at that edge restarts the counter at line 0 and pulses `frame_start`. `disp_off_in` replaces the local display-on flag, and the three timing outputs are held at 0. When fed from a source copy with the same settings, the follower's row address lags the source's by one cycle, and its segment pattern matches the source's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = timing source, 0 = follower |
| duty_sel | input | 2 | Duty code: 0=9, 1=17, 2=33, 3=65 lines |
| cfg_we | input | 1 | Load display flags |
| cfg_disp_on | input | 1 | Display-on flag value |
| cfg_reverse | input | 1 | Invert flag value |
| cfg_all_on | input | 1 | All-lit flag value |
| start_we | input | 1 | Load first-row offset |
| start_val | input | 7 | First-row offset value (0..64) |
| ram_row_data | input | SEG_W | RAM bits of the addressed row |
| line_clk_in | input | 1 | Line clock from source (follower mode) |
| frame_pol_in | input | 1 | Frame polarity from source (follower mode) |
| disp_off_in | input | 1 | Blanking state from source (follower mode) |
| ram_row_addr | output | 7 | Display-RAM row to read |
| seg_out | output | SEG_W | Registered segment lit pattern |
| line_clk_out | output | 1 | Line clock (source mode) |
| frame_pol_out | output | 1 | Frame polarity (source mode) |
| disp_off_out | output | 1 | Blanking state (source mode) |
| frame_start | output | 1 | One-cycle pulse at line 0 of each frame |

## Verification
All four duty codes are run for more than two frames each. This separates the 4-cycle divider from the 8-cycle divider and the 9, 17, 33 and 65 wrap points.

Offsets of 0, 10 and 64 test the modulo-65 fold. A rejected write of 70 shows that an out-of-range offset is dropped.

A pseudo-random RAM pattern is run under blanked, normal, inverted, all-lit-with-invert and blanked-with-all-lit settings, which shows the priority order.

A follower copy is driven from the source copy's outputs, and its own display-on flag is set to the opposite value. This shows that it follows the source's blanking and stays one cycle behind.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_9  = 2'd0,
    DUTY_17 = 2'd1,
    DUTY_33 = 2'd2,
    DUTY_65 = 2'd3
  } duty_e;

  // Scanned lines per frame for each duty code.
  function automatic int unsigned duty_lines(duty_e d);
    case (d)
      DUTY_9:  return 9;
      DUTY_17: return 17;
      DUTY_33: return 33;
      default: return 65;
    endcase
  endfunction

endpackage

// File: rtl/lcd_line_div.sv
module lcd_line_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             line_clk
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last_val;
  logic [DIV_W-1:0] fall_val;

  assign last_val = div_val - DIV_W'(1);
  assign fall_val = (div_val >> 1) - DIV_W'(1);
  assign tick     = run && (cnt >= last_val);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      line_clk <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      line_clk <= 1'b1;
    end else begin
      cnt <= cnt + DIV_W'(1);
      if (cnt == fall_val) line_clk <= 1'b0;
    end
  end

  // R2: after a line tick the divider restarts from zero
  p_div_restart_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

  // R2: the line clock is high in the cycle after a tick
  p_lclk_rise_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> line_clk);

endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             is_master,
  input  logic             pol_in,
  input  logic [ROW_W-1:0] lines_val,
  output logic [ROW_W-1:0] line_cnt,
  output logic             frame_pol,
  output logic             frame_start
);

  logic at_last;
  assign at_last = (line_cnt >= lines_val - ROW_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt    <= '0;
      frame_pol   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (tick) begin
        if (!is_master && (pol_in != frame_pol)) begin
          line_cnt    <= '0;
          frame_pol   <= pol_in;
          frame_start <= 1'b1;
        end else if (at_last) begin
          line_cnt <= '0;
          if (is_master) begin
            frame_pol   <= ~frame_pol;
            frame_start <= 1'b1;
          end
        end else begin
          line_cnt <= line_cnt + ROW_W'(1);
        end
      end
    end
  end

  // R3: a tick on the last line returns the counter to line 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && is_master && at_last) |=> (line_cnt == '0));

  // R4: the frame strobe only fires together with a polarity change
  p_pol_flip_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (frame_pol != $past(frame_pol)));

  // R4: the frame strobe lasts one cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

endmodule

// File: rtl/lcd_seg_mask.sv
module lcd_seg_mask #(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_W-1:0] row_bits,
  input  logic             blank,
  input  logic             all_lit,
  input  logic             invert,
  output logic [SEG_W-1:0] seg_q
);

  always_ff @(posedge clk) begin
    if (rst)          seg_q <= '0;
    else if (blank)   seg_q <= '0;
    else if (all_lit) seg_q <= '1;
    else if (invert)  seg_q <= ~row_bits;
    else              seg_q <= row_bits;
  end

  // R7: blanking darkens every segment on the next cycle
  p_blank_dark_r7: assert property (@(posedge clk) disable iff (rst)
    blank |=> (seg_q == '0));

  // R7: all-lit, when not blanked, lights every segment
  p_all_lit_r7: assert property (@(posedge clk) disable iff (rst)
    (!blank && all_lit) |=> (seg_q == '1));

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int NUM_ROWS = 65,
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         is_master,
  input  logic [1:0]                   duty_sel,
  input  logic                         cfg_we,
  input  logic                         cfg_disp_on,
  input  logic                         cfg_reverse,
  input  logic                         cfg_all_on,
  input  logic                         start_we,
  input  logic [$clog2(NUM_ROWS)-1:0]  start_val,
  input  logic [SEG_W-1:0]             ram_row_data,
  input  logic                         line_clk_in,
  input  logic                         frame_pol_in,
  input  logic                         disp_off_in,
  output logic [$clog2(NUM_ROWS)-1:0]  ram_row_addr,
  output logic [SEG_W-1:0]             seg_out,
  output logic                         line_clk_out,
  output logic                         frame_pol_out,
  output logic                         disp_off_out,
  output logic                         frame_start
);

  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int DIV_W = $clog2(DIV_SLOW + 1);

  duty_e            duty;
  logic [DIV_W-1:0] div_val;
  logic [ROW_W-1:0] lines_val;

  assign duty      = duty_e'(duty_sel);
  assign div_val   = (duty == DUTY_65) ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);
  assign lines_val = ROW_W'(duty_lines(duty));

  // Configuration and follower input registers
  logic [ROW_W-1:0] start_r;
  logic             disp_on_r, reverse_r, all_on_r;
  logic             lclk_in_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_r   <= '0;
      disp_on_r <= 1'b0;
      reverse_r <= 1'b0;
      all_on_r  <= 1'b0;
      lclk_in_d <= 1'b0;
    end else begin
      if (start_we && (start_val <= ROW_W'(NUM_ROWS - 1))) start_r <= start_val;
      if (cfg_we) begin
        disp_on_r <= cfg_disp_on;
        reverse_r <= cfg_reverse;
        all_on_r  <= cfg_all_on;
      end
      lclk_in_d <= line_clk_in;
    end
  end

  // Line timing: local divider or edges of the source's line clock
  logic div_tick, div_lclk, line_tick;

  lcd_line_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (is_master),
    .div_val  (div_val),
    .tick     (div_tick),
    .line_clk (div_lclk)
  );

  assign line_tick = is_master ? div_tick : (line_clk_in && !lclk_in_d);

  logic [ROW_W-1:0] line_cnt;
  logic             frame_pol;

  lcd_line_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .tick        (line_tick),
    .is_master   (is_master),
    .pol_in      (frame_pol_in),
    .lines_val   (lines_val),
    .line_cnt    (line_cnt),
    .frame_pol   (frame_pol),
    .frame_start (frame_start)
  );

  // Row address: offset plus line, folded once into 0..NUM_ROWS-1
  logic [ROW_W:0] row_sum;
  assign row_sum      = {1'b0, start_r} + {1'b0, line_cnt};
  assign ram_row_addr = (row_sum >= (ROW_W+1)'(NUM_ROWS))
                        ? ROW_W'(row_sum - (ROW_W+1)'(NUM_ROWS))
                        : row_sum[ROW_W-1:0];

  // Segment pattern
  logic blank_eff;
  assign blank_eff = is_master ? !disp_on_r : disp_off_in;

  lcd_seg_mask #(.SEG_W(SEG_W)) u_seg (
    .clk      (clk),
    .rst      (rst),
    .row_bits (ram_row_data),
    .blank    (blank_eff),
    .all_lit  (all_on_r),
    .invert   (reverse_r),
    .seg_q    (seg_out)
  );

  assign line_clk_out  = is_master && div_lclk;
  assign frame_pol_out = is_master && frame_pol;
  assign disp_off_out  = is_master && !disp_on_r;

  // R5: the row address never leaves the RAM
  p_row_range_r5: assert property (@(posedge clk) disable iff (rst)
    ram_row_addr < ROW_W'(NUM_ROWS));

  // R5: an out-of-range offset write leaves the offset unchanged
  p_start_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (start_we && (start_val > ROW_W'(NUM_ROWS - 1))) |=> $stable(start_r));

endmodule

// File: tb/test_lcd_scan_timing.sv
module test_lcd_scan_timing;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [1:0]    duty_sel = 2'd2;
  logic          cfg_we = 1'b0, cfg_disp_on = 1'b0, cfg_reverse = 1'b0, cfg_all_on = 1'b0;
  logic          start_we = 1'b0;
  logic [6:0]    start_val = '0;
  logic [SW-1:0] ram_row_data = 16'hACE1;

  logic [6:0]    ram_row_addr, s_row;
  logic [SW-1:0] seg_out, s_seg;
  logic          line_clk_out, frame_pol_out, disp_off_out, frame_start;
  logic          s_lclk, s_pol, s_off, s_fs;

  lcd_scan_timing #(.SEG_W(SW)) i_lcd_scan_timing (
    .clk(clk), .rst(rst), .is_master(1'b1), .duty_sel(duty_sel),
    .cfg_we(cfg_we), .cfg_disp_on(cfg_disp_on), .cfg_reverse(cfg_reverse),
    .cfg_all_on(cfg_all_on), .start_we(start_we), .start_val(start_val),
    .ram_row_data(ram_row_data), .line_clk_in(1'b0), .frame_pol_in(1'b0),
    .disp_off_in(1'b0), .ram_row_addr(ram_row_addr), .seg_out(seg_out),
    .line_clk_out(line_clk_out), .frame_pol_out(frame_pol_out),
    .disp_off_out(disp_off_out), .frame_start(frame_start));

  // Follower copy; its own display-on flag is set opposite (must be ignored)
  lcd_scan_timing #(.SEG_W(SW)) i_lcd_scan_timing_slave (
    .clk(clk), .rst(rst), .is_master(1'b0), .duty_sel(duty_sel),
    .cfg_we(cfg_we), .cfg_disp_on(!cfg_disp_on), .cfg_reverse(cfg_reverse),
    .cfg_all_on(cfg_all_on), .start_we(start_we), .start_val(start_val),
    .ram_row_data(ram_row_data), .line_clk_in(line_clk_out),
    .frame_pol_in(frame_pol_out), .disp_off_in(disp_off_out),
    .ram_row_addr(s_row), .seg_out(s_seg), .line_clk_out(s_lclk),
    .frame_pol_out(s_pol), .disp_off_out(s_off), .frame_start(s_fs));

  integer checks = 0, failures = 0;
  bit     done = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_div = 0, m_line = 0, m_line_prev = 0, m_start = 0, m_pol = 0, m_fs = 0, m_lclk = 0;
  int m_on = 0, m_rev = 0, m_all = 0;
  logic [SW-1:0] m_seg = '0;

  function automatic int nlines(input logic [1:0] d);
    case (d) 2'd0: return 9; 2'd1: return 17; 2'd2: return 33; default: return 65; endcase
  endfunction

  always @(posedge clk) begin
    int dv, ln;
    bit tk;
    m_line_prev = m_line;
    if (rst) begin
      m_div = 0; m_line = 0; m_start = 0; m_pol = 0; m_fs = 0; m_lclk = 0;
      m_on = 0; m_rev = 0; m_all = 0; m_seg = '0; m_line_prev = 0;
    end else begin
      dv = (duty_sel == 2'd3) ? 4 : 8;
      ln = nlines(duty_sel);
      tk = (m_div >= dv - 1);
      if (m_on == 0) m_seg = '0;
      else if (m_all != 0) m_seg = '1;
      else if (m_rev != 0) m_seg = ~ram_row_data;
      else m_seg = ram_row_data;
      m_fs = 0;
      if (tk) begin
        m_div = 0; m_lclk = 1;
        if (m_line >= ln - 1) begin m_line = 0; m_pol ^= 1; m_fs = 1; end
        else m_line++;
      end else begin
        if (m_div == dv / 2 - 1) m_lclk = 0;
        m_div++;
      end
      if (start_we && start_val <= 64) m_start = start_val;
      if (cfg_we) begin m_on = cfg_disp_on; m_rev = cfg_reverse; m_all = cfg_all_on; end
    end
  end

  // Pseudo-random RAM row contents
  always @(negedge clk)
    ram_row_data <= {ram_row_data[14:0], ram_row_data[15] ^ ram_row_data[13] ^ ram_row_data[12] ^ ram_row_data[10]};

  // Per-cycle comparison plus period/frame-length counters
  int cyc = 0, last_rise = -1, rises = 0;
  bit prev_lclk = 0, armed = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_rise = -1; rises = 0; armed = 0; prev_lclk = 0;
    end else if (!done) begin
      chk(ram_row_addr == 7'((m_start + m_line) % 65), "R5 row address", ram_row_addr, (m_start + m_line) % 65);
      chk(line_clk_out == m_lclk[0], "R2 line clock", line_clk_out, m_lclk);
      chk(frame_pol_out == m_pol[0], "R4 frame polarity", frame_pol_out, m_pol);
      chk(frame_start == m_fs[0], "R4 frame strobe", frame_start, m_fs);
      chk(disp_off_out == (m_on == 0), "R8 display-off output", disp_off_out, m_on == 0);
      chk(seg_out == m_seg, "R6 R7 segment pattern", seg_out, m_seg);
      chk(s_row == 7'((m_start + m_line_prev) % 65), "R9 follower row", s_row, (m_start + m_line_prev) % 65);
      chk(s_seg == m_seg, "R9 follower segments", s_seg, m_seg);
      chk({s_lclk, s_pol, s_off} == 3'b000, "R9 follower outputs quiet", {s_lclk, s_pol, s_off}, 0);
      if (line_clk_out && !prev_lclk) begin
        rises++;
        if (last_rise >= 0)
          chk(cyc - last_rise == ((duty_sel == 2'd3) ? 4 : 8), "R2 line clock period", cyc - last_rise, (duty_sel == 2'd3) ? 4 : 8);
        last_rise = cyc;
      end
      if (frame_start) begin
        if (armed) chk(rises == nlines(duty_sel), "R3 lines per frame", rises, nlines(duty_sel));
        rises = 0; armed = 1;
      end
      prev_lclk = line_clk_out;
    end
  end

  task automatic do_reset(input logic [1:0] d);
    rst = 1'b1; duty_sel = d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(ram_row_addr == 0, "R1 row after reset", ram_row_addr, 0);
    chk(seg_out == '0, "R1 segments after reset", seg_out, 0);
    chk(frame_pol_out == 1'b0, "R1 polarity after reset", frame_pol_out, 0);
    chk(disp_off_out == 1'b1, "R1 blanked after reset", disp_off_out, 1);
  endtask

  task automatic set_cfg(input bit on, input bit rev, input bit all);
    cfg_we = 1'b1; cfg_disp_on = on; cfg_reverse = rev; cfg_all_on = all;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_start(input logic [6:0] v);
    start_we = 1'b1; start_val = v;
    @(negedge clk);
    start_we = 1'b0;
  endtask

  initial begin
    do_reset(2'd2);
    repeat (50) @(negedge clk);              // R7: still blanked
    set_cfg(1, 0, 0);                         // R6 normal
    repeat (600) @(negedge clk);
    set_start(7'd10);                         // R5 offset
    repeat (300) @(negedge clk);
    set_start(7'd70);                         // R5 rejected write
    repeat (100) @(negedge clk);
    set_cfg(1, 1, 0);                         // R6 invert
    repeat (100) @(negedge clk);
    set_cfg(1, 1, 1);                         // R7 all-lit over invert
    repeat (100) @(negedge clk);
    set_cfg(0, 0, 1);                         // R7 blank over all-lit
    repeat (100) @(negedge clk);
    set_cfg(1, 0, 0);
    set_start(7'd64);                         // R5 fold at the top row
    repeat (300) @(negedge clk);
    for (int d = 0; d < 4; d++) begin
      if (d == 2) continue;
      do_reset(2'(d));                        // R2 R3 per duty
      set_cfg(1, 0, 0);
      set_start(7'd40);
      repeat ((d == 3) ? 700 : (d == 1) ? 400 : 250) @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule